// File: doc/BRIEF.md
# Complementary Output Auto-Shutdown Controller

This block stands between a complementary waveform generator core and its four output pins, named A, B, C and D here. In normal operation it passes the core's drive values straight to the pins with every output enable asserted. When a shutdown event is sampled, or software raises the status flag, it replaces the pin values with a programmed safe state. Each pin pair has its own selector: A/C use one and B/D use the other. The choices are a forced high, a forced low, a released (tri-stated) pin, or the pin's polarity-aware idle level. The idle level is applied only after the dead band has completed.

Leaving shutdown takes two steps. First the status flag must clear. Software can clear it with a write. If automatic restart is enabled, hardware clears it once the event input has dropped. After that, the pins stay in their safe state until the waveform data input shows a rising edge, which lines the restart up with the start of a new period.

Top module: `cmp_outsafe`

## Requirements
- R1: After reset the status flag is 0, automatic restart is off, and both pair selectors hold 01 (tri-state). A later shutdown made with no configuration write therefore releases every pin.
- R2: A shutdown event sampled high at a clock edge sets the status flag and enters the shutdown state at that edge. Pins change only from the cycle after the event is sampled.
- R3: A configuration write with the status value 1 enters shutdown when no event is present.
- R4: With automatic restart off, the status flag stays 1 after the event drops, until a configuration write with status value 0.
- R5: With automatic restart on, the status flag stays 1 while the event input is high. It clears at the first clock edge that samples the event low.
- R6: If an event and a software write of status 0 fall in the same cycle, the event wins and the flag stays 1.
- R7: Once the flag is 0, the pins keep their safe state until a rising edge of the data input is sampled (input 1 now, 0 at the previous edge). Normal drive returns in the cycle after that edge. An edge in the same cycle as the clearing write counts.
- R8: A rising edge of the data input while the status flag is still 1 does not end shutdown.
- R9: Selector value 11 drives the pin high and value 10 drives it low, with the output enable asserted in both cases.
- R10: Selector value 01 deasserts the pin's output enable and drives the pin value 0.
- R11: Selector value 00 holds the pin at the value it had in the cycle the shutdown began, until the dead-band-done input is sampled high during shutdown. From the next cycle the pin takes its idle level. The dead-band record is cleared whenever the block is not in shutdown.
- R12: Pins at even indices (A=bit 0, C=bit 2) follow the A/C selector. Pins at odd indices (B=bit 1, D=bit 3) follow the B/D selector.
- R13: Outside shutdown every pin equals its drive input and every output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_stat | input | 1 | Status flag value to write |
| cfg_autorst | input | 1 | Automatic restart enable value to write |
| cfg_sel_ac | input | 2 | Safe-state selector for pins A/C |
| cfg_sel_bd | input | 2 | Safe-state selector for pins B/D |
| trip_in | input | 1 | Synchronous shutdown event |
| wave_in | input | 1 | Waveform generator data input |
| drv_in | input | NPIN | Normal drive values, bit 0 = A |
| idle_lvl | input | NPIN | Idle level per pin, with polarity applied |
| db_done | input | 1 | Dead band has completed |
| stat_o | output | 1 | Shutdown status flag |
| pin_o | output | NPIN | Pin values |
| oe_o | output | NPIN | Per-pin output enables |

## Verification
The properties assume that every input is synchronous to the clock and stable around the rising edge. They also assume a configuration write is a single-cycle strobe that carries all fields at once, so every write also sets the status flag. The bench changes inputs only on the falling edge and holds each one for at least a full cycle. Whenever it writes selectors it resends the intended status value. It returns the data input low for a cycle before each release, so that every rising edge is seen against a known previous sample.

// File: rtl/outsafe_pkg.sv
package outsafe_pkg;

  typedef enum logic [1:0] {
    SAFE_IDLE = 2'b00,
    SAFE_TRI  = 2'b01,
    SAFE_LO   = 2'b10,
    SAFE_HI   = 2'b11
  } safe_sel_e;

  localparam int NPAIR = 2;

  // Returns {output_enable, value} for one pin held in shutdown.
  function automatic logic [1:0] safe_drive(safe_sel_e sel, logic held,
                                            logic idle, logic db_ok);
    logic [1:0] r;
    unique case (sel)
      SAFE_HI:   r = 2'b11;
      SAFE_LO:   r = 2'b10;
      SAFE_TRI:  r = 2'b00;
      default:   r = {1'b1, (db_ok ? idle : held)};
    endcase
    return r;
  endfunction

  // Pair index that drives pin idx: even pins use pair 0, odd pins use pair 1.
  function automatic int pair_of(int idx);
    return idx % NPAIR;
  endfunction

endpackage

// File: rtl/outsafe_cfg.sv
module outsafe_cfg
  import outsafe_pkg::*;
#(
  parameter int NP = NPAIR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  autorst_wr,
  input  logic [NP-1:0][1:0]    sel_wr,
  output logic                  autorst,
  output logic [NP-1:0][1:0]    sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  autorst <= 1'b0;
    else if (we) autorst <= autorst_wr;
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel[p] <= SAFE_TRI;
      else if (we) sel[p] <= sel_wr[p];
    end
  end

endmodule

// File: rtl/outsafe_trip.sv
module outsafe_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic cfg_we,
  input  logic cfg_stat,
  input  logic autorst,
  input  logic wave_in,
  input  logic db_done,
  output logic stat_q,
  output logic shut_q,
  output logic db_seen_q,
  output logic wave_rise,
  output logic auto_clr,
  output logic release_ev
);

  logic wave_q;
  logic stat_d;
  logic shut_d;

  assign wave_rise = wave_in & ~wave_q;
  assign auto_clr  = autorst & stat_q & ~trip_in & ~cfg_we;

  // Event beats a software write, which beats the automatic clear.
  always_comb begin
    if (trip_in)       stat_d = 1'b1;
    else if (cfg_we)   stat_d = cfg_stat;
    else if (auto_clr) stat_d = 1'b0;
    else               stat_d = stat_q;
  end

  assign shut_d     = stat_d | (shut_q & ~wave_rise);
  assign release_ev = shut_q & ~shut_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= 1'b0;
      shut_q    <= 1'b0;
      wave_q    <= 1'b0;
      db_seen_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      shut_q <= shut_d;
      wave_q <= wave_in;
      if (!shut_q)      db_seen_q <= 1'b0;
      else if (db_done) db_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/outsafe_pin.sv
module outsafe_pin
  import outsafe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shut,
  input  logic       db_ok,
  input  logic [1:0] sel,
  input  logic       drv,
  input  logic       idle,
  output logic       pin,
  output logic       oe
);

  logic frz_q;

  // Tracks the last normally driven value; frozen while in shutdown.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frz_q <= 1'b0;
    else if (!shut) frz_q <= drv;
  end

  always_comb begin
    if (shut) {oe, pin} = safe_drive(safe_sel_e'(sel), frz_q, idle, db_ok);
    else      {oe, pin} = {1'b1, drv};
  end

endmodule

// File: rtl/cmp_outsafe.sv
module cmp_outsafe
  import outsafe_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_stat,
  input  logic            cfg_autorst,
  input  logic [1:0]      cfg_sel_ac,
  input  logic [1:0]      cfg_sel_bd,
  input  logic            trip_in,
  input  logic            wave_in,
  input  logic [NPIN-1:0] drv_in,
  input  logic [NPIN-1:0] idle_lvl,
  input  logic            db_done,
  output logic            stat_o,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] oe_o
);

  logic                  autorst_w;
  logic [NPAIR-1:0][1:0] sel_w;
  logic                  shut_w;
  logic                  db_seen_w;
  logic                  wave_rise_w;
  logic                  auto_clr_w;
  logic                  release_w;

  outsafe_cfg #(.NP(NPAIR)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .autorst_wr (cfg_autorst),
    .sel_wr     ({cfg_sel_bd, cfg_sel_ac}),
    .autorst    (autorst_w),
    .sel        (sel_w)
  );

  outsafe_trip u_trip (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_in    (trip_in),
    .cfg_we     (cfg_we),
    .cfg_stat   (cfg_stat),
    .autorst    (autorst_w),
    .wave_in    (wave_in),
    .db_done    (db_done),
    .stat_q     (stat_o),
    .shut_q     (shut_w),
    .db_seen_q  (db_seen_w),
    .wave_rise  (wave_rise_w),
    .auto_clr   (auto_clr_w),
    .release_ev (release_w)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    outsafe_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .shut  (shut_w),
      .db_ok (db_seen_w),
      .sel   (sel_w[pair_of(i)]),
      .drv   (drv_in[i]),
      .idle  (idle_lvl[i]),
      .pin   (pin_o[i]),
      .oe    (oe_o[i])
    );
  end

endmodule

// File: rtl/outsafe_chk.sv
module outsafe_chk #(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trip_in,
  input logic            cfg_we,
  input logic            cfg_stat,
  input logic            stat_o,
  input logic            shut_w,
  input logic            autorst_w,
  input logic            db_seen_w,
  input logic            wave_rise_w,
  input logic            auto_clr_w,
  input logic [1:0]      sel_ac_w,
  input logic [NPIN-1:0] drv_in,
  input logic [NPIN-1:0] pin_o,
  input logic [NPIN-1:0] oe_o
);

  assert_trip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_in |=> (stat_o && shut_w));

  assert_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_stat) |=> shut_w);

  assert_hold_no_auto_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !autorst_w && !cfg_we) |=> stat_o);

  assert_auto_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_clr_w |=> !stat_o);

  assert_trip_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_in && cfg_we && !cfg_stat) |=> stat_o);

  assert_wait_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_w && !wave_rise_w) |=> shut_w);

  assert_set_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !autorst_w && !cfg_we) |=> shut_w);

  assert_tri_ac_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_w && sel_ac_w == 2'b01) |-> (!oe_o[0] && !pin_o[0]));

  assert_db_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_w |=> !db_seen_w);

  assert_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_w |-> (pin_o == drv_in && &oe_o));

endmodule

bind cmp_outsafe outsafe_chk #(.NPIN(NPIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trip_in     (trip_in),
  .cfg_we      (cfg_we),
  .cfg_stat    (cfg_stat),
  .stat_o      (stat_o),
  .shut_w      (shut_w),
  .autorst_w   (autorst_w),
  .db_seen_w   (db_seen_w),
  .wave_rise_w (wave_rise_w),
  .auto_clr_w  (auto_clr_w),
  .sel_ac_w    (sel_w[0]),
  .drv_in      (drv_in),
  .pin_o       (pin_o),
  .oe_o        (oe_o)
);

// File: tb/sim_cmp_outsafe.sv
`timescale 1ns/1ps
module sim_cmp_outsafe;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_stat = 1'b0, cfg_autorst = 1'b0;
  logic [1:0] cfg_sel_ac = 2'b01, cfg_sel_bd = 2'b01;
  logic       trip_in = 1'b0, wave_in = 1'b0, db_done = 1'b0;
  logic [3:0] drv_in = 4'b0110, idle_lvl = 4'b1001;
  logic       stat_o;
  logic [3:0] pin_o, oe_o;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  cmp_outsafe #(.NPIN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stat(cfg_stat),
    .cfg_autorst(cfg_autorst), .cfg_sel_ac(cfg_sel_ac), .cfg_sel_bd(cfg_sel_bd),
    .trip_in(trip_in), .wave_in(wave_in), .drv_in(drv_in), .idle_lvl(idle_lvl),
    .db_done(db_done), .stat_o(stat_o), .pin_o(pin_o), .oe_o(oe_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic st, input logic ar,
                           input logic [1:0] ac, input logic [1:0] bd);
    cfg_stat = st; cfg_autorst = ar; cfg_sel_ac = ac; cfg_sel_bd = bd;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic wave_pulse();
    wave_in = 1'b0; @(negedge clk);
    wave_in = 1'b1; @(negedge clk);
    wave_in = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", {7'd0, stat_o}, 8'd0);
    chk("R13 pins pass through", {4'd0, pin_o}, 8'h06);
    chk("R13 enables on", {4'd0, oe_o}, 8'h0F);
  endtask

  task automatic t_trip_manual();
    trip_in = 1'b1; #1;
    chk("R2 no change before edge", {4'd0, oe_o}, 8'h0F);
    @(negedge clk); trip_in = 1'b0; #1;
    chk("R2 status set", {7'd0, stat_o}, 8'd1);
    chk("R1 reset selector tri-states", {4'd0, oe_o}, 8'h00);
    chk("R10 tri pin value", {4'd0, pin_o}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R4 stays set without auto", {7'd0, stat_o}, 8'd1);
    cfg_write(1'b0, 1'b0, 2'b01, 2'b01);
    chk("R4 software clear", {7'd0, stat_o}, 8'd0);
    @(negedge clk);
    chk("R7 held until edge", {4'd0, oe_o}, 8'h00);
    wave_in = 1'b1; #1;
    chk("R7 no release before edge sampled", {4'd0, oe_o}, 8'h00);
    @(negedge clk); wave_in = 1'b0; #1;
    chk("R7 released after edge", {4'd0, oe_o}, 8'h0F);
    chk("R7 normal drive back", {4'd0, pin_o}, 8'h06);
    @(negedge clk);
  endtask

  task automatic t_auto();
    drv_in = 4'b1010;
    cfg_write(1'b0, 1'b1, 2'b11, 2'b10);
    trip_in = 1'b1; @(negedge clk); #1;
    chk("R9 forced levels", {4'd0, pin_o}, 8'h05);
    chk("R9 enables on", {4'd0, oe_o}, 8'h0F);
    @(negedge clk); trip_in = 1'b0; #1;
    chk("R5 set while event high", {7'd0, stat_o}, 8'd1);
    @(negedge clk); #1;
    chk("R5 auto clear", {7'd0, stat_o}, 8'd0);
    chk("R7 still safe after auto clear", {4'd0, pin_o}, 8'h05);
    wave_in = 1'b1; @(negedge clk); wave_in = 1'b0; #1;
    chk("R7 release after auto clear", {4'd0, pin_o}, 8'h0A);
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    drv_in = 4'b0101;
    cfg_write(1'b1, 1'b0, 2'b10, 2'b11);
    chk("R3 software entry", {7'd0, stat_o}, 8'd1);
    chk("R12 pair mapping", {4'd0, pin_o}, 8'h0A);
    wave_in = 1'b1;
    cfg_write(1'b0, 1'b0, 2'b10, 2'b11);
    chk("R7 edge with clear counts", {4'd0, pin_o}, 8'h05);
    wave_in = 1'b0; @(negedge clk);
  endtask

  task automatic t_edge_while_set();
    cfg_write(1'b1, 1'b0, 2'b01, 2'b11);
    chk("R10 A/C tri, B/D high enables", {4'd0, oe_o}, 8'h0A);
    chk("R12 pin values", {4'd0, pin_o}, 8'h0A);
    wave_in = 1'b1; @(negedge clk); #1;
    chk("R8 edge ignored while set", {4'd0, oe_o}, 8'h0A);
    cfg_write(1'b0, 1'b0, 2'b01, 2'b11);
    @(negedge clk); #1;
    chk("R8 no new edge, still safe", {4'd0, oe_o}, 8'h0A);
    wave_pulse(); #1;
    chk("R7 release on fresh edge", {4'd0, oe_o}, 8'h0F);
  endtask

  task automatic t_priority();
    cfg_write(1'b1, 1'b0, 2'b01, 2'b01);
    trip_in = 1'b1;
    cfg_write(1'b0, 1'b0, 2'b01, 2'b01);
    trip_in = 1'b0;
    chk("R6 event beats clear", {7'd0, stat_o}, 8'd1);
    cfg_write(1'b0, 1'b0, 2'b01, 2'b01);
    wave_pulse(); #1;
    chk("R6 release after clear", {4'd0, oe_o}, 8'h0F);
  endtask

  task automatic t_idle();
    cfg_write(1'b0, 1'b0, 2'b00, 2'b00);
    drv_in = 4'b0110; idle_lvl = 4'b1001;
    trip_in = 1'b1; @(negedge clk);
    trip_in = 1'b0; drv_in = 4'b1111; #1;
    chk("R11 frozen before dead band", {4'd0, pin_o}, 8'h06);
    db_done = 1'b1; #1;
    chk("R11 not yet idle", {4'd0, pin_o}, 8'h06);
    @(negedge clk); db_done = 1'b0; #1;
    chk("R11 idle after dead band", {4'd0, pin_o}, 8'h09);
    cfg_write(1'b0, 1'b0, 2'b00, 2'b00);
    wave_pulse(); #1;
    chk("R13 normal after idle", {4'd0, pin_o}, 8'h0F);
    drv_in = 4'b0011; trip_in = 1'b1; @(negedge clk); trip_in = 1'b0; #1;
    chk("R11 dead-band record cleared", {4'd0, pin_o}, 8'h03);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_trip_manual();
    t_auto();
    t_same_cycle();
    t_edge_while_set();
    t_priority();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule